// File: doc/BRIEF.md
# Fast Link Pulse Burst Decoder

This block sits behind an analog link-pulse detector on a twisted-pair receiver. It turns the stream of detected pulses back into the 16-bit code word that a link partner sends during speed and duplex negotiation. Every burst has a fixed frame of timing pulses, with an optional data pulse halfway between each neighbouring pair. The decoder measures the interval since the last framing pulse in ticks of a slow timebase. From that interval it decides whether each arriving pulse is framing, data, or misplaced.

A word is only released when the burst is complete and regular. A clean burst has seventeen framing pulses, every pulse lands inside its window, and the burst starts after a long quiet period. The finished word then appears with a single-cycle valid strobe and stays on the word output until the next good burst. Any irregularity throws the burst away and produces a one-cycle error strobe. The irregularities are a misplaced pulse, a missing framing pulse, a pulse that follows too soon after the previous activity, or an extra pulse after the seventeenth. All interval limits are parameters in timebase ticks. The defaults assume a 1 us tick: a data window of 55 to 70, a framing window of 111 to 139 and a quiet gap of 5000.

Top module: `flp_burst_decoder`

## Requirements
- R1: While reset is low, and on the cycle after it is released, `word_o` is 0 and `word_valid_o` and `err_o` are 0.
- R2: A pulse starts a burst only if more than GAP_TICKS ticks have passed since the last accepted pulse or error, or if no pulse has arrived since reset. A pulse that arrives sooner produces one `err_o` strobe and starts nothing. This covers an eighteenth pulse after a complete burst.
- R3: If a pulse arrives DATA_MIN to DATA_MAX ticks after a framing pulse, it is a data pulse and the slot decodes as 1. If the next pulse arrives CLK_MIN to CLK_MAX ticks after the framing pulse, it is framing. A slot with no data pulse decodes as 0.
- R4: The slot after the first framing pulse becomes bit 0 of `word_o`, the next slot becomes bit 1, and so on up to bit 15.
- R5: `word_valid_o` is high for exactly one cycle. That cycle follows the clock edge that samples the seventeenth framing pulse, and `word_o` carries the new word in that same cycle.
- R6: A pulse outside its window ends the burst with one `err_o` strobe. This includes a second data pulse in one slot. No valid strobe follows, and `word_o` keeps the previous word.
- R7: Mid-burst silence longer than CLK_MAX ticks after a framing pulse ends the burst with an `err_o` strobe and no valid strobe.
- R8: Intervals are counted only on cycles where `tick_i` is high, so decoding depends on tick count and not on the clock-cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| pulse_i | input | 1 | Detected link pulse, one cycle wide |
| word_o | output | 16 | Last complete code word, bit 0 first on the line |
| word_valid_o | output | 1 | One-cycle strobe for a new word |
| err_o | output | 1 | One-cycle strobe for a rejected burst or pulse |

## Verification
Each pulse is registered on the edge that samples it. The valid strobe, the new word and the error strobe caused by a misplaced pulse are therefore all due on the cycle right after that edge. The bench drives each pulse for one cycle from the falling edge and reads the result at the next falling edge, so the valid and word checks land on the due cycle, and a further cycle confirms the strobe has dropped. A timeout error only becomes due after CLK_MAX ticks, so errors are counted on falling edges and the count is compared a few cycles after the last stimulus of each case.

// File: rtl/flp_pkg.sv
// Shared types for the link pulse burst decoder.
package flp_pkg;
    // Decoder position inside a burst.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,  // waiting for the first pulse after quiet
        ST_AFT_CLK = 2'd1,  // last accepted pulse was framing
        ST_AFT_DAT = 2'd2   // a data pulse was seen in the current slot
    } flp_state_e;
endpackage

// File: rtl/flp_tick_timer.sv
// Counts timebase ticks since the last clear, saturating at LIMIT.
// Assumes tick_i is a single-cycle strobe. Reset loads LIMIT so the line
// counts as quiet straight after reset.
module flp_tick_timer #(
    parameter int LIMIT = 5001,
    parameter int TW    = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          clr_i,
    output logic [TW-1:0] cnt_o
);
    localparam logic [TW-1:0] L_LIMIT = TW'(LIMIT);

    // Clear on request, otherwise advance on each tick up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= L_LIMIT;
        else if (clr_i)
            cnt_o <= '0;
        else if (tick_i && cnt_o != L_LIMIT)
            cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/flp_window_class.sv
// Sorts the current interval into the timing windows the decoder uses.
// Purely combinational. Assumes DATA_MAX < CLK_MIN.
module flp_window_class #(
    parameter int DATA_MIN  = 55,
    parameter int DATA_MAX  = 70,
    parameter int CLK_MIN   = 111,
    parameter int CLK_MAX   = 139,
    parameter int GAP_TICKS = 5000,
    parameter int TW        = 13
) (
    input  logic [TW-1:0] cnt_i,
    output logic          in_data_o,
    output logic          in_clk_o,
    output logic          late_o,
    output logic          quiet_o
);
    localparam logic [TW-1:0] L_DMIN = TW'(DATA_MIN);
    localparam logic [TW-1:0] L_DMAX = TW'(DATA_MAX);
    localparam logic [TW-1:0] L_CMIN = TW'(CLK_MIN);
    localparam logic [TW-1:0] L_CMAX = TW'(CLK_MAX);
    localparam logic [TW-1:0] L_GAP  = TW'(GAP_TICKS);

    // Window decode of the tick interval.
    always_comb begin
        in_data_o = (cnt_i >= L_DMIN) && (cnt_i <= L_DMAX);
        in_clk_o  = (cnt_i >= L_CMIN) && (cnt_i <= L_CMAX);
        late_o    = (cnt_i > L_CMAX);
        quiet_o   = (cnt_i > L_GAP);
    end
endmodule

// File: rtl/flp_word_shifter.sv
// Collects slot bits, the first slot ending up in bit 0 after all shifts.
// Assumes exactly W shifts per burst; clr_i starts a fresh word.
module flp_word_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    // Shift new bits in from the top so the oldest settles at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            word_o <= '0;
        else if (shift_i)
            word_o <= {bit_i, word_o[W-1:1]};
    end
endmodule

// File: rtl/flp_burst_decoder.sv
// Link pulse burst decoder: recovers one code word per burst of framing
// and data pulses by interval timing, and rejects irregular bursts.
// Assumes pulse_i and tick_i are single-cycle strobes in the clk domain
// and that all window limits are given in ticks.
module flp_burst_decoder #(
    parameter int DATA_MIN  = 55,
    parameter int DATA_MAX  = 70,
    parameter int CLK_MIN   = 111,
    parameter int CLK_MAX   = 139,
    parameter int GAP_TICKS = 5000,
    parameter int NUM_CLK   = 17,
    localparam int WORD_W   = NUM_CLK - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              pulse_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_valid_o,
    output logic              err_o
);
    import flp_pkg::*;

    localparam int LIMIT = ((GAP_TICKS > CLK_MAX) ? GAP_TICKS : CLK_MAX) + 1;
    localparam int TW    = $clog2(LIMIT + 1);
    localparam int CNT_W = $clog2(NUM_CLK + 1);
    localparam logic [CNT_W-1:0] L_LAST = CNT_W'(NUM_CLK - 1);

    flp_state_e         state, nxt;
    logic [TW-1:0]      ivl;
    logic [CNT_W-1:0]   clk_cnt;
    logic [WORD_W-1:0]  sh_word;
    logic               in_data, in_clk, late, quiet;
    logic               start, clk_acc, bit_val, fault, last, tmr_clr;
    logic               busy;

    flp_tick_timer #(.LIMIT(LIMIT), .TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .clr_i(tmr_clr), .cnt_o(ivl)
    );

    flp_window_class #(
        .DATA_MIN(DATA_MIN), .DATA_MAX(DATA_MAX), .CLK_MIN(CLK_MIN),
        .CLK_MAX(CLK_MAX), .GAP_TICKS(GAP_TICKS), .TW(TW)
    ) u_class (
        .cnt_i(ivl), .in_data_o(in_data), .in_clk_o(in_clk),
        .late_o(late), .quiet_o(quiet)
    );

    flp_word_shifter #(.W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr_i(start), .shift_i(clk_acc),
        .bit_i(bit_val), .word_o(sh_word)
    );

    // Classify the current pulse or timeout and pick the next position.
    always_comb begin
        nxt     = state;
        start   = 1'b0;
        clk_acc = 1'b0;
        bit_val = 1'b0;
        fault   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (pulse_i) begin
                    if (quiet) start = 1'b1;
                    else       fault = 1'b1;
                end
            end
            ST_AFT_CLK: begin
                if (pulse_i) begin
                    if (in_data)     nxt = ST_AFT_DAT;
                    else if (in_clk) clk_acc = 1'b1;
                    else             fault = 1'b1;
                end else if (late) begin
                    fault = 1'b1;
                end
            end
            ST_AFT_DAT: begin
                if (pulse_i) begin
                    if (in_clk) begin
                        clk_acc = 1'b1;
                        bit_val = 1'b1;
                    end else begin
                        fault = 1'b1;
                    end
                end else if (late) begin
                    fault = 1'b1;
                end
            end
            default: fault = 1'b1;
        endcase
        last = clk_acc && (clk_cnt == L_LAST);
        if (start)   nxt = ST_AFT_CLK;
        if (clk_acc) nxt = last ? ST_IDLE : ST_AFT_CLK;
        if (fault)   nxt = ST_IDLE;
        tmr_clr = start | clk_acc | fault;
    end

    // Burst position and framing pulse count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            clk_cnt <= '0;
        end else begin
            state <= nxt;
            if (start)        clk_cnt <= CNT_W'(1);
            else if (clk_acc) clk_cnt <= clk_cnt + 1'b1;
        end
    end

    // Result registers: word kept until the next good burst, one-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o       <= '0;
            word_valid_o <= 1'b0;
            err_o        <= 1'b0;
        end else begin
            word_valid_o <= last;
            err_o        <= fault;
            if (last) word_o <= {bit_val, sh_word[WORD_W-1:1]};
        end
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/flp_burst_decoder_chk.sv
// Temporal checks on the burst decoder, attached by bind.
module flp_burst_decoder_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pulse_i,
    input logic [WORD_W-1:0] word_o,
    input logic              word_valid_o,
    input logic              err_o,
    input logic              busy
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |=> !word_valid_o);                                  // R5
    AST_VALID_FROM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> ($past(pulse_i) && $past(busy)));                // R5
    AST_IDLE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> !busy);                                          // R2
    AST_WORD_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_o) |-> word_valid_o);                               // R6
    AST_NO_VALID_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_valid_o && err_o));                                        // R6
    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($past(pulse_i) || $past(busy)));                       // R7
endmodule

bind flp_burst_decoder flp_burst_decoder_chk #(.WORD_W(WORD_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .pulse_i(pulse_i), .word_o(word_o),
    .word_valid_o(word_valid_o), .err_o(err_o), .busy(busy)
);

// File: tb/flp_burst_decoder_tb_top.sv
// Bench for the burst decoder, using short windows so many bursts fit.
module flp_burst_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b1;
    logic        pulse_i = 1'b0;
    logic [15:0] word_o;
    logic        word_valid_o;
    logic        err_o;

    int checks = 0;
    int errs = 0;
    int cyc = 0;
    int err_seen = 0;
    int val_seen = 0;
    bit half = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flp_burst_decoder #(
        .DATA_MIN(6), .DATA_MAX(8), .CLK_MIN(12), .CLK_MAX(16),
        .GAP_TICKS(40), .NUM_CLK(17)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pulse_i(pulse_i),
        .word_o(word_o), .word_valid_o(word_valid_o), .err_o(err_o)
    );

    // Strobe counters, sampled away from the active edge.
    always @(negedge clk) begin
        if (err_o) err_seen++;
        if (word_valid_o) val_seen++;
    end

    localparam int NV = 6;
    localparam logic [31:0] VEC [NV] = '{
        {16'h0001, 16'h0001}, {16'h8000, 16'h8000}, {16'hA5C3, 16'hA5C3},
        {16'hFFFF, 16'hFFFF}, {16'h0000, 16'h0000}, {16'h05E1, 16'h05E1}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        tick_i = half ? cyc[0] : 1'b1;
    endtask

    task automatic gap(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic emit();
        pulse_i = 1'b1;
        step();
        pulse_i = 1'b0;
    endtask

    // One burst; sc scales spacing in cycles. Returns on the cycle after the last pulse edge.
    task automatic send_word(input logic [15:0] w, input int sc);
        emit();
        for (int i = 0; i < 16; i++) begin
            if (w[i]) begin
                gap(7 * sc);
                emit();
                gap(6 * sc + (sc - 1));
            end else begin
                gap(14 * sc);
            end
            emit();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errs);
            $finish;
        end
    end

    initial begin
        int e0, v0;
        logic [15:0] prev;
        gap(4);
        chk(word_o == 16'h0 && !word_valid_o && !err_o, "R1 reset outputs",
            {word_o, 14'h0, word_valid_o, err_o}, 32'h0);
        rst_n = 1'b1;
        step();
        chk(word_o == 16'h0 && !word_valid_o && !err_o, "R1 after release",
            {word_o, 14'h0, word_valid_o, err_o}, 32'h0);

        // Table walk: R2 start after reset/quiet, R3 slot bits, R4 order, R5 strobe.
        for (int v = 0; v < NV; v++) begin
            gap(45);
            send_word(VEC[v][31:16], 1);
            chk(word_valid_o == 1'b1, "R5 valid due", {31'h0, word_valid_o}, 1);
            chk(word_o == VEC[v][15:0], "R3 R4 word", {16'h0, word_o}, {16'h0, VEC[v][15:0]});
            step();
            chk(word_valid_o == 1'b0, "R5 valid one cycle", {31'h0, word_valid_o}, 0);
        end
        gap(5);
        chk(err_seen == 0, "R3 no error on good bursts", err_seen, 0);
        prev = word_o;

        // R2: pulse too soon after a finished burst (acts as an 18th pulse).
        gap(45);
        send_word(16'h1234, 1);
        chk(word_o == 16'h1234, "R4 word before extra pulse", {16'h0, word_o}, 32'h1234);
        e0 = err_seen; v0 = val_seen;
        gap(13);
        emit();
        chk(err_o == 1'b1, "R2 extra pulse error due", {31'h0, err_o}, 1);
        gap(3);
        chk(err_seen == e0 + 1, "R2 one error strobe", err_seen, e0 + 1);
        chk(val_seen == v0 + 1, "R2 no new word", val_seen, v0 + 1);
        prev = word_o;

        // R6: data pulse too early.
        gap(45);
        e0 = err_seen; v0 = val_seen;
        emit(); gap(4); emit();
        chk(err_o == 1'b1, "R6 early pulse error due", {31'h0, err_o}, 1);
        gap(40);
        chk(err_seen == e0 + 1 && val_seen == v0, "R6 early pulse discarded", err_seen - e0, 1);
        chk(word_o == prev, "R6 word kept", {16'h0, word_o}, {16'h0, prev});

        // R6: two data pulses in one slot.
        gap(45);
        e0 = err_seen;
        emit(); gap(7); emit(); gap(2); emit();
        chk(err_o == 1'b1, "R6 second data pulse error due", {31'h0, err_o}, 1);
        gap(40);
        chk(err_seen == e0 + 1 && word_o == prev, "R6 second data pulse", err_seen - e0, 1);

        // R6: pulse between the data and framing windows.
        gap(45);
        e0 = err_seen;
        emit(); gap(10); emit();
        gap(40);
        chk(err_seen == e0 + 1, "R6 gap-window pulse", err_seen - e0, 1);

        // R7: framing pulse missing mid-burst.
        gap(45);
        e0 = err_seen; v0 = val_seen;
        emit();
        for (int i = 0; i < 5; i++) begin gap(14); emit(); end
        gap(30);
        chk(err_seen == e0 + 1, "R7 timeout error", err_seen - e0, 1);
        chk(val_seen == v0 && word_o == prev, "R7 no word", val_seen - v0, 0);

        // R7: only sixteen framing pulses.
        gap(45);
        e0 = err_seen; v0 = val_seen;
        emit();
        for (int i = 0; i < 15; i++) begin gap(14); emit(); end
        gap(30);
        chk(err_seen == e0 + 1 && val_seen == v0, "R7 short burst", err_seen - e0, 1);

        // R8: ticks on alternate cycles; cycle spacing doubled.
        half = 1'b1;
        gap(95);
        e0 = err_seen;
        send_word(16'h3C69, 2);
        chk(word_valid_o == 1'b1, "R8 valid with slow ticks", {31'h0, word_valid_o}, 1);
        chk(word_o == 16'h3C69, "R8 word with slow ticks", {16'h0, word_o}, 32'h3C69);
        gap(3);
        chk(err_seen == e0, "R8 no error with slow ticks", err_seen - e0, 0);
        half = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end
endmodule